// File: doc/BRIEF.md
# I2C Double-Buffered Data Register Unit

This block sits between a CPU-side register port and the byte-level side of an I2C engine. It holds the data register that software writes for transmission and reads after reception. A mode input selects 8-bit or 16-bit use. A direction input selects which of the two paths is active.

Each direction has two stages: the data register and a holding buffer behind it. Software can therefore queue one further item while the current one is still in progress. Words are moved low byte first in both directions. The block raises a transmit-ready flag and a receive-ready flag. It flags transmit underflow and receive overrun. While a received byte has no space to go to, it asks the bus side to stretch SCL low, so no data is lost.

The shifter exchanges single bytes with the block through a valid/ready pair in each direction. A separate input tells the block, in slave mode, that the external master is still asking for data.

Top module: `i2c_dreg_unit`

## Requirements
- R1: In word mode (`word_mode_i`=1), a write is accepted only when `reg_be_i`=2'b11. Any other byte-enable pattern leaves the register unchanged. In byte mode, a write is accepted when `reg_be_i[0]`=1. Only bits 7:0 are sent, as one byte per write. A received byte reads back zero-extended on `reg_rdata_o`.
- R2: The transmit path holds two items. `tx_rdy_flag_o` is high while the holding stage is empty. A write made while it is low is dropped. Items leave in the order they were written.
- R3: In word mode, bits 7:0 of a written word are offered on `tx_byte_o` before bits 15:8.
- R4: The receive path holds two complete items. `rx_rdy_flag_o` is high while the data register holds an unread item. A read (`reg_rd_i`) returns the oldest item on `reg_rdata_o` in the same cycle and removes it.
- R5: In word mode, the first byte received forms bits 7:0 of the word and the second byte forms bits 15:8.
- R6: In master mode (`master_i`=1) in transmit direction, `tx_udf_o` sets when the shifter requests a byte (`tx_ready_i`) and no item is pending.
- R7: In slave mode, underflow sets only if `slv_req_i` is also high. Without it, an empty request leaves `tx_udf_o` low.
- R8: `tx_udf_o` is sticky. It clears on an accepted write or when `en_i` goes low.
- R9: In receive direction, when a byte is offered while both receive stages are full, the block does three things: `rx_ready_o` is low, `scl_hold_o` is high in the same cycle, and `rx_ovr_o` sets at the next edge.
- R10: `rx_ovr_o` is sticky. It clears on any read or when `en_i` goes low.
- R11: With `en_i` low, `scl_hold_o`, `tx_rdy_flag_o` and `tx_valid_o` drop at once. All buffers empty at the next edge, and `rx_rdy_flag_o` stays low.
- R12: Writes made in receive direction (`tx_dir_i`=0) are dropped. At no time are `tx_valid_o` and `rx_ready_o` high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; low flushes all state |
| word_mode_i | input | 1 | 1 = 16-bit register, 0 = 8-bit |
| tx_dir_i | input | 1 | 1 = transmit, 0 = receive |
| master_i | input | 1 | 1 = master mode |
| slv_req_i | input | 1 | External master still requesting data (slave mode) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_be_i | input | 2 | Byte enables of the write |
| reg_wdata_i | input | 2*BYTE_W | Write data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 2*BYTE_W | Receive data register contents |
| tx_rdy_flag_o | output | 1 | Transmit register can take a value |
| rx_rdy_flag_o | output | 1 | Receive register holds unread data |
| tx_udf_o | output | 1 | Transmit underflow flag |
| rx_ovr_o | output | 1 | Receive overrun flag |
| scl_hold_o | output | 1 | Request to hold SCL low |
| tx_byte_o | output | BYTE_W | Byte offered to the shifter |
| tx_valid_o | output | 1 | tx_byte_o is valid |
| tx_ready_i | input | 1 | Shifter loads a byte / requests one |
| rx_byte_i | input | BYTE_W | Byte from the shifter |
| rx_valid_i | input | 1 | rx_byte_i is valid |
| rx_ready_o | output | 1 | Block accepts rx_byte_i |

## Verification
The bench builds the block with BYTE_W=8, which gives the 16-bit register width and 2-bit byte enables that software sees. With that width, random data covers every byte value in both halves of a word, so a swap of low and high byte cannot go unseen. Two entries per direction are reached within a few cycles, so the full and overrun states come up often under random handshakes, next to the directed fill-and-stall cases.

// File: rtl/i2c_dreg_pkg.sv
package i2c_dreg_pkg;
  // Write acceptance by access width: word needs both lanes, byte needs lane 0
  function automatic logic lane_ok(input logic word_mode, input logic [1:0] be);
    return word_mode ? (be == 2'b11) : be[0];
  endfunction
endpackage

// File: rtl/i2c_dreg_tx.sv
module i2c_dreg_tx
  import i2c_dreg_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tx_dir_i,
  input  logic              word_mode_i,
  input  logic              master_i,
  input  logic              slv_req_i,
  input  logic              wr_i,
  input  logic [1:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              tx_rdy_o,
  output logic              tx_udf_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  logic [DW-1:0] dr_q, hold_q, wval;
  logic dr_v_q, hold_v_q, hi_sel_q, udf_q;
  logic act, wr_ok, xfer, last, udf_set;

  assign act        = en_i & tx_dir_i;
  assign tx_rdy_o   = act & ~hold_v_q;
  assign wr_ok      = tx_rdy_o & wr_i & lane_ok(word_mode_i, be_i);
  assign wval       = word_mode_i ? wdata_i : {{BYTE_W{1'b0}}, wdata_i[BYTE_W-1:0]};
  assign tx_valid_o = act & dr_v_q;
  assign tx_byte_o  = (word_mode_i & hi_sel_q) ? dr_q[DW-1:BYTE_W] : dr_q[BYTE_W-1:0];
  assign xfer       = tx_valid_o & tx_ready_i;
  assign last       = xfer & (~word_mode_i | hi_sel_q);
  assign udf_set    = act & tx_ready_i & ~dr_v_q & (master_i | slv_req_i);
  assign tx_udf_o   = udf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q <= '0; hold_q <= '0;
      dr_v_q <= 1'b0; hold_v_q <= 1'b0; hi_sel_q <= 1'b0; udf_q <= 1'b0;
    end else if (!en_i) begin
      dr_v_q <= 1'b0; hold_v_q <= 1'b0; hi_sel_q <= 1'b0; udf_q <= 1'b0;
    end else begin
      if (xfer) hi_sel_q <= ~last;
      if (last) begin
        if (hold_v_q) begin
          dr_q     <= hold_q;
          hold_v_q <= 1'b0;
        end else begin
          dr_v_q <= 1'b0;
        end
      end
      if (wr_ok) begin
        if (dr_v_q && !last) begin
          hold_q   <= wval;
          hold_v_q <= 1'b1;
        end else begin
          dr_q   <= wval;
          dr_v_q <= 1'b1;
        end
      end
      if (wr_ok)        udf_q <= 1'b0;
      else if (udf_set) udf_q <= 1'b1;
    end
  end

  AST_TX_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !last) |=> dr_v_q);  // R2
  AST_TX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!dr_v_q && !hold_v_q && !tx_udf_o));  // R11
  AST_TX_UDF_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && master_i && tx_ready_i && !dr_v_q && !wr_i) |=> tx_udf_o);  // R6
  AST_TX_UDF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> !tx_udf_o);  // R8
endmodule

// File: rtl/i2c_dreg_rx.sv
module i2c_dreg_rx #(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_dir_i,
  input  logic              word_mode_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rx_rdy_o,
  output logic              rx_ovr_o,
  output logic              scl_hold_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o
);
  logic [DW-1:0] dr_q, hold_q, item;
  logic [BYTE_W-1:0] lo_q;
  logic dr_v_q, hold_v_q, lo_v_q, ovr_q;
  logic act, full, take, complete, pop, dr_busy;

  assign act        = en_i & rx_dir_i;
  assign full       = dr_v_q & hold_v_q;
  assign rx_ready_o = act & ~full;
  assign scl_hold_o = act & rx_valid_i & full;
  assign take       = rx_valid_i & rx_ready_o;
  assign complete   = take & (~word_mode_i | lo_v_q);
  assign item       = word_mode_i ? {rx_byte_i, lo_q} : {{BYTE_W{1'b0}}, rx_byte_i};
  assign pop        = rd_i & en_i & dr_v_q;
  assign dr_busy    = dr_v_q & (~pop | hold_v_q);
  assign rdata_o    = dr_q;
  assign rx_rdy_o   = en_i & dr_v_q;
  assign rx_ovr_o   = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q <= '0; hold_q <= '0; lo_q <= '0;
      dr_v_q <= 1'b0; hold_v_q <= 1'b0; lo_v_q <= 1'b0; ovr_q <= 1'b0;
    end else if (!en_i) begin
      dr_v_q <= 1'b0; hold_v_q <= 1'b0; lo_v_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (take) begin
        if (word_mode_i && !lo_v_q) begin
          lo_q   <= rx_byte_i;
          lo_v_q <= 1'b1;
        end else begin
          lo_v_q <= 1'b0;
        end
      end
      if (pop) begin
        if (hold_v_q) begin
          dr_q     <= hold_q;
          hold_v_q <= 1'b0;
        end else begin
          dr_v_q <= 1'b0;
        end
      end
      if (complete) begin
        if (dr_busy) begin
          hold_q   <= item;
          hold_v_q <= 1'b1;
        end else begin
          dr_q   <= item;
          dr_v_q <= 1'b1;
        end
      end
      if (rd_i)            ovr_q <= 1'b0;
      else if (scl_hold_o) ovr_q <= 1'b1;
    end
  end

  AST_RX_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && rx_valid_i && !rx_ready_o) |-> scl_hold_o);  // R9
  AST_RX_NO_TAKE_WHEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hold_o |-> !rx_ready_o);  // R9
  AST_RX_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !rx_ovr_o);  // R10
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!dr_v_q && !hold_v_q && !lo_v_q));  // R11
endmodule

// File: rtl/i2c_dreg_unit.sv
module i2c_dreg_unit #(
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              word_mode_i,
  input  logic              tx_dir_i,
  input  logic              master_i,
  input  logic              slv_req_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_be_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              tx_rdy_flag_o,
  output logic              rx_rdy_flag_o,
  output logic              tx_udf_o,
  output logic              rx_ovr_o,
  output logic              scl_hold_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o
);
  i2c_dreg_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i, .rst_ni, .en_i, .tx_dir_i, .word_mode_i, .master_i, .slv_req_i,
    .wr_i(reg_wr_i), .be_i(reg_be_i), .wdata_i(reg_wdata_i),
    .tx_rdy_o(tx_rdy_flag_o), .tx_udf_o, .tx_byte_o, .tx_valid_o, .tx_ready_i
  );

  i2c_dreg_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i, .rst_ni, .en_i, .rx_dir_i(~tx_dir_i), .word_mode_i,
    .rd_i(reg_rd_i), .rdata_o(reg_rdata_o), .rx_rdy_o(rx_rdy_flag_o),
    .rx_ovr_o, .scl_hold_o, .rx_byte_i, .rx_valid_i, .rx_ready_o
  );

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_valid_o && rx_ready_o));  // R12
endmodule

// File: tb/i2c_dreg_unit_tb_top.sv
module i2c_dreg_unit_tb_top;
  localparam int BW = 8;
  localparam int DW = 2 * BW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en, word_mode, tx_dir, master, slv_req, reg_wr, reg_rd, tx_ready, rx_valid;
  logic [1:0] reg_be;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [BW-1:0] tx_byte, rx_byte;
  logic tx_rdy_flag, rx_rdy_flag, tx_udf, rx_ovr, scl_hold, tx_valid, rx_ready;

  int checks = 0, failures = 0;
  logic [BW-1:0] tq[$];
  logic [BW-1:0] rq[$];

  always #4 clk = ~clk;

  i2c_dreg_unit #(.BYTE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni, .en_i(en), .word_mode_i(word_mode), .tx_dir_i(tx_dir),
    .master_i(master), .slv_req_i(slv_req), .reg_wr_i(reg_wr), .reg_be_i(reg_be),
    .reg_wdata_i(reg_wdata), .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata),
    .tx_rdy_flag_o(tx_rdy_flag), .rx_rdy_flag_o(rx_rdy_flag), .tx_udf_o(tx_udf),
    .rx_ovr_o(rx_ovr), .scl_hold_o(scl_hold), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .rx_byte_i(rx_byte), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input logic wm, input logic [BW-1:0] b0,
                                             input logic [BW-1:0] b1);
    return wm ? {b1, b0} : {{BW{1'b0}}, b0};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] be, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic take_tx(input string req, input logic [BW-1:0] exp);
    tx_ready = 1'b1; #1;
    chk(req, {tx_valid, tx_byte}, {1'b1, exp});
    tick();
    tx_ready = 1'b0;
  endtask

  task automatic send_rx(input logic [BW-1:0] b);
    rx_valid = 1'b1; rx_byte = b; #1;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic rd_rx(input string req, input logic [DW-1:0] exp);
    reg_rd = 1'b1; #1;
    chk(req, reg_rdata, exp);
    tick();
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    en = 0; word_mode = 1; tx_dir = 1; master = 0; slv_req = 0; reg_wr = 0; reg_rd = 0;
    tx_ready = 0; rx_valid = 0; reg_be = 0; reg_wdata = 0; rx_byte = 0;
    repeat (3) @(posedge clk); #1;
    rst_ni = 1'b1; #1;
    // reset state
    chk("R11 reset", {tx_valid, tx_rdy_flag, rx_rdy_flag, tx_udf, rx_ovr, scl_hold},
        6'b0);

    // ---- transmit, word mode
    en = 1; tick();
    wr(2'b01, 16'h1234);
    chk("R1 byte write ignored in word mode", tx_valid, 1'b0);
    wr(2'b11, 16'hBEEF);
    chk("R2 ready with hold empty", tx_rdy_flag, 1'b1);
    wr(2'b11, 16'h1122);
    chk("R2 not ready with hold full", tx_rdy_flag, 1'b0);
    wr(2'b11, 16'h3344);  // dropped
    take_tx("R3 low byte first", 8'hEF);
    take_tx("R3 high byte second", 8'hBE);
    take_tx("R2 held word low", 8'h22);
    take_tx("R2 held word high", 8'h11);
    chk("R2 write while full dropped", tx_valid, 1'b0);
    tx_ready = 1; tick();
    chk("R7 slave without request no underflow", tx_udf, 1'b0);
    slv_req = 1; tick();
    chk("R7 slave with request underflow", tx_udf, 1'b1);
    slv_req = 0; tx_ready = 0;
    wr(2'b11, 16'h55AA);
    chk("R8 write clears underflow", tx_udf, 1'b0);
    take_tx("R3 low byte", 8'hAA);
    take_tx("R3 high byte", 8'h55);
    master = 1; tx_ready = 1; tick();
    chk("R6 master underflow", tx_udf, 1'b1);
    tx_ready = 0; en = 0; #1;
    chk("R11 tx ready drops at once", tx_rdy_flag, 1'b0);
    tick();
    chk("R8 disable clears underflow", tx_udf, 1'b0);
    master = 0; en = 1;

    // ---- transmit, byte mode
    word_mode = 0; tick();
    wr(2'b01, 16'hABCD);
    take_tx("R1 byte mode low byte only", 8'hCD);
    #1 chk("R1 one byte per write", tx_valid, 1'b0);

    // ---- write in receive direction is dropped
    word_mode = 1; tx_dir = 0; tick();
    wr(2'b11, 16'hCAFE);
    tx_dir = 1; #1;
    chk("R12 write in rx direction dropped", tx_valid, 1'b0);

    // ---- receive, word mode
    tx_dir = 0; tick();
    send_rx(8'h11); send_rx(8'h22);
    chk("R4 rx ready flag", rx_rdy_flag, 1'b1);
    chk("R5 first byte low", reg_rdata, 16'h2211);
    send_rx(8'h33); send_rx(8'h44);
    rx_valid = 1; rx_byte = 8'h55; #1;
    chk("R9 not ready when full", rx_ready, 1'b0);
    chk("R9 scl hold when full", scl_hold, 1'b1);
    tick();
    chk("R9 overrun set", rx_ovr, 1'b1);
    reg_rd = 1; #1;
    chk("R4 read oldest", reg_rdata, 16'h2211);
    tick(); reg_rd = 0;
    chk("R10 read clears overrun", rx_ovr, 1'b0);
    tick(); rx_valid = 0;  // 0x55 taken
    send_rx(8'h66);
    rd_rx("R4 second item", 16'h4433);
    rd_rx("R5 pair after stall", 16'h6655);
    chk("R4 empty after reads", rx_rdy_flag, 1'b0);

    // ---- disable while stalled
    send_rx(8'h01); send_rx(8'h02); send_rx(8'h03); send_rx(8'h04);
    rx_valid = 1; rx_byte = 8'h77; tick();
    chk("R9 overrun before disable", rx_ovr, 1'b1);
    en = 0; #1;
    chk("R11 scl released at once", scl_hold, 1'b0);
    tick();
    chk("R10 disable clears overrun", rx_ovr, 1'b0);
    rx_valid = 0; en = 1; #1;
    chk("R11 buffers flushed", {rx_rdy_flag, rx_ready}, 2'b01);

    // ---- receive, byte mode
    word_mode = 0; tick();
    send_rx(8'h7E);
    rd_rx("R1 byte rx zero-extended", 16'h007E);

    // ---- random transmit phases
    for (int ph = 0; ph < 2; ph++) begin
      en = 0; tick();
      en = 1; tx_dir = 1; word_mode = (ph == 0); tq.delete(); tick();
      for (int c = 0; c < 3000; c++) begin
        logic do_wr, rdy;
        logic [1:0] be;
        logic [DW-1:0] d;
        do_wr = tx_rdy_flag && ($urandom % 3 == 0);
        be = word_mode ? 2'b11 : 2'($urandom);
        d = DW'($urandom);
        rdy = 1'($urandom);
        reg_wr = do_wr; reg_be = be; reg_wdata = d; tx_ready = rdy; #1;
        chk("R2 valid tracks pending data", tx_valid, (tq.size() != 0));
        if (tx_valid && rdy && tq.size() != 0)
          chk(word_mode ? "R3 random word order" : "R2 random byte order",
              tx_byte, tq.pop_front());
        if (do_wr && be[0]) begin
          tq.push_back(d[BW-1:0]);
          if (word_mode) tq.push_back(d[DW-1:BW]);
        end
        tick();
      end
      reg_wr = 0; tx_ready = 0;
    end

    // ---- random receive phases
    for (int ph = 0; ph < 2; ph++) begin
      logic pend;
      pend = 0;
      en = 0; tick();
      en = 1; tx_dir = 0; word_mode = (ph == 0); rq.delete(); tick();
      for (int c = 0; c < 3000; c++) begin
        logic do_rd;
        if (!pend && ($urandom % 2 == 0)) begin
          pend = 1; rx_byte = BW'($urandom);
        end
        do_rd = rx_rdy_flag && ($urandom % 3 == 0);
        rx_valid = pend; reg_rd = do_rd; #1;
        chk("R9 stall iff byte refused", scl_hold, pend && !rx_ready);
        if (do_rd) begin
          if (rq.size() >= (word_mode ? 2 : 1)) begin
            chk(word_mode ? "R5 random word" : "R4 random byte", reg_rdata,
                exp_word(word_mode, rq[0], word_mode ? rq[1] : 8'h00));
            void'(rq.pop_front());
            if (word_mode) void'(rq.pop_front());
          end else begin
            chk("R4 read with no expected item", 1'b1, 1'b0);
          end
        end
        if (pend && rx_ready) begin
          rq.push_back(rx_byte);
          pend = 0;
        end
        tick();
      end
      rx_valid = 0; reg_rd = 0;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule